// File: doc/BRIEF.md
# Backplane Trigger Router with Derived Sync Clock

This block drives eight shared backplane trigger lines. Each line has its own source selector. A line can copy a front-panel input, another trigger line, a star-trigger line, a software trigger, or a derived synchronization clock. Every consumer on the backplane sees the same value on a given line, so one routed event can start several downstream units at the same time.

The synchronization clock starts from one of three reference clocks. That reference is shared by all routes. It feeds two power-of-two dividers in cascade. Each line then picks its own tap: the undivided reference, the first divider output, or the second divider output.

All asynchronous inputs are brought into the block clock through two flops. Every line output is registered, so lines that select each other cannot form a combinational loop. A software trigger is a one-cycle strobe. It is held high until the synchronization clock next rises.

Top module: `trig_route_matrix`

## Requirements
- R1: Each line has a 6-bit source code. Codes 0–5 pick front-panel input 0–5, 6–13 pick trigger line 0–7, 14–30 pick star line 0–16, 31 picks the software trigger and 32 picks the synchronization clock. Any code above 32 drives the line low.
- R2: Front-panel, star and reference inputs pass through a two-flop synchronizer. A change on a routed front-panel or star input appears on the line at the third rising clock edge after the change.
- R3: Line outputs are registered. A line that selects another line follows it one clock later, so chains and self-selection stay loop-free.
- R4: The 2-bit base select picks the shared reference: 0 the DDS clock, 1 the 10 MHz backplane clock, 2 front-panel input 0, 3 the DDS clock.
- R5: The first divider divides the reference by 2^n. Its exponent n is a 4-bit field: 0 means divide by 1, and values above 9 behave as 9. The output has a 50% duty cycle counted in reference periods.
- R6: The second divider divides the first divider's output by 2^m. Its exponent m follows the same encoding and clamp as n.
- R7: Each line has a 2-bit tap select for code 32: 0 full rate, 1 first divider, 2 second divider, 3 full rate.
- R8: Both divider counters restart from zero when the base select or either clamped exponent changes. A divided output that was high therefore drops even while the reference is idle.
- R9: A software strobe sets a hold flag on the next clock edge. The flag stays set until the first rising edge of the selected reference and clears on the edge after that rise. A new strobe takes priority over clearing.
- R10: Each line's output enable equals its enable bit, delayed by one clock. While the enable is clear, the line output reads 0.
- R11: During reset all lines and all output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fp_in | input | 6 | Asynchronous front-panel inputs |
| star_in | input | 17 | Asynchronous star-trigger inputs |
| dds_clk | input | 1 | DDS reference clock (sampled) |
| bp_clk10 | input | 1 | 10 MHz backplane reference (sampled) |
| base_sel | input | 2 | Shared reference select |
| exp1 | input | 4 | First divider exponent |
| exp2 | input | 4 | Second divider exponent |
| line_src_sel | input | 48 | Per-line source code, 6 bits per line, line 0 in the low bits |
| line_tap_sel | input | 16 | Per-line sync tap, 2 bits per line |
| line_en | input | 8 | Per-line drive enable |
| sw_strobe | input | 1 | One-cycle software trigger strobe |
| trig_out | output | 8 | Routed trigger line values |
| trig_oe | output | 8 | Per-line output enables |

## Verification
The hardest state to reach from the ports is a divider restart. With a running reference the restart cannot be told apart from a normal toggle. The bench therefore stops the DDS reference right after a divided output rises, then rewrites the base select to its alias code. A correct restart is the only way the line can fall. The software-trigger stretch is isolated the same way: front-panel input 0 is the reference and is held low, so the flag must persist, and it must clear only after that input is raised.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;

  typedef enum logic [1:0] {
    TAP_FULL = 2'd0,
    TAP_DIV1 = 2'd1,
    TAP_DIV2 = 2'd2,
    TAP_ALT  = 2'd3
  } tap_e;

  typedef enum logic [1:0] {
    BASE_DDS   = 2'd0,
    BASE_CLK10 = 2'd1,
    BASE_FP0   = 2'd2,
    BASE_ALIAS = 2'd3
  } base_e;

  // Saturating limit applied to a divider exponent field.
  function automatic int unsigned clamp_exp(input int unsigned e, input int unsigned lim);
    return (e > lim) ? lim : e;
  endfunction

endpackage

// File: rtl/trig_sync2.sv
module trig_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/trig_pow2_div.sv
module trig_pow2_div #(
  parameter int EXP_W   = 4,
  parameter int EXP_MAX = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             in_lvl,
  input  logic [EXP_W-1:0] exp_c,
  output logic             in_rise,
  output logic             out_lvl
);
  localparam int CNT_W = (EXP_MAX > 0) ? EXP_MAX : 1;

  logic             prev;
  logic [CNT_W-1:0] cnt;

  assign in_rise = in_lvl & ~prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      cnt  <= '0;
    end else begin
      prev <= in_lvl;
      if (restart)      cnt <= '0;
      else if (in_rise) cnt <= cnt + 1'b1;
    end
  end

  // Bit k of the rise counter has a period of 2^(k+1) input rises.
  always_comb begin
    out_lvl = in_lvl;
    for (int k = 0; k < CNT_W; k++) begin
      if (int'(exp_c) == k + 1) out_lvl = cnt[k];
    end
  end
endmodule

// File: rtl/trig_line_mux.sv
module trig_line_mux
  import trig_route_pkg::*;
#(
  parameter int N_DIRECT = 32,
  parameter int SEL_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_DIRECT-1:0] src_vec,
  input  logic                sync_full,
  input  logic                sync_div1,
  input  logic                sync_div2,
  input  logic [SEL_W-1:0]    sel,
  input  logic [1:0]          tap,
  input  logic                en,
  output logic                line_q,
  output logic                oe_q
);
  localparam int IDX_W = (N_DIRECT > 1) ? $clog2(N_DIRECT) : 1;

  logic nxt;
  logic tap_lvl;

  always_comb begin
    case (tap_e'(tap))
      TAP_DIV1: tap_lvl = sync_div1;
      TAP_DIV2: tap_lvl = sync_div2;
      default:  tap_lvl = sync_full;
    endcase
  end

  always_comb begin
    if (int'(sel) == N_DIRECT)     nxt = tap_lvl;
    else if (int'(sel) < N_DIRECT) nxt = src_vec[sel[IDX_W-1:0]];
    else                           nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      line_q <= en & nxt;
      oe_q   <= en;
    end
  end
endmodule

// File: rtl/trig_route_matrix.sv
module trig_route_matrix
  import trig_route_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int N_FP    = 6,
  parameter int N_STAR  = 17,
  parameter int EXP_W   = 4,
  parameter int EXP_MAX = 9,
  parameter int SEL_W   = $clog2(N_FP + N_LINES + N_STAR + 2)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_FP-1:0]          fp_in,
  input  logic [N_STAR-1:0]        star_in,
  input  logic                     dds_clk,
  input  logic                     bp_clk10,
  input  logic [1:0]               base_sel,
  input  logic [EXP_W-1:0]         exp1,
  input  logic [EXP_W-1:0]         exp2,
  input  logic [N_LINES*SEL_W-1:0] line_src_sel,
  input  logic [N_LINES*2-1:0]     line_tap_sel,
  input  logic [N_LINES-1:0]       line_en,
  input  logic                     sw_strobe,
  output logic [N_LINES-1:0]       trig_out,
  output logic [N_LINES-1:0]       trig_oe
);
  localparam int N_DIRECT = N_FP + N_LINES + N_STAR + 1;
  localparam int CFG_W    = 2 + 2 * EXP_W;

  logic [N_FP-1:0]     fp_s;
  logic [N_STAR-1:0]   star_s;
  logic [1:0]          ref_s;
  logic                base_lvl;
  logic                base_rise;
  logic                div1_lvl;
  logic                div2_lvl;
  logic                div1_rise;
  logic [EXP_W-1:0]    e1c;
  logic [EXP_W-1:0]    e2c;
  logic [CFG_W-1:0]    cfg_q;
  logic                cfg_restart;
  logic                sw_hold;
  logic [N_DIRECT-1:0] src_vec;
  logic [N_LINES-1:0]  line_q;
  logic [N_LINES-1:0]  oe_q;

  trig_sync2 #(.W(N_FP))   u_sync_fp   (.clk(clk), .rst_n(rst_n), .d(fp_in),   .q(fp_s));
  trig_sync2 #(.W(N_STAR)) u_sync_star (.clk(clk), .rst_n(rst_n), .d(star_in), .q(star_s));
  trig_sync2 #(.W(2))      u_sync_ref  (.clk(clk), .rst_n(rst_n),
                                        .d({bp_clk10, dds_clk}), .q(ref_s));

  always_comb begin
    case (base_e'(base_sel))
      BASE_CLK10: base_lvl = ref_s[1];
      BASE_FP0:   base_lvl = fp_s[0];
      default:    base_lvl = ref_s[0];
    endcase
  end

  assign e1c = EXP_W'(clamp_exp(int'(exp1), EXP_MAX));
  assign e2c = EXP_W'(clamp_exp(int'(exp2), EXP_MAX));

  assign cfg_restart = ({base_sel, e1c, e2c} != cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {base_sel, e1c, e2c};
  end

  trig_pow2_div #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_div1 (
    .clk(clk), .rst_n(rst_n), .restart(cfg_restart), .in_lvl(base_lvl),
    .exp_c(e1c), .in_rise(base_rise), .out_lvl(div1_lvl));

  trig_pow2_div #(.EXP_W(EXP_W), .EXP_MAX(EXP_MAX)) u_div2 (
    .clk(clk), .rst_n(rst_n), .restart(cfg_restart), .in_lvl(div1_lvl),
    .exp_c(e2c), .in_rise(div1_rise), .out_lvl(div2_lvl));

  // Software trigger held until the shared reference next rises.
  always_ff @(posedge clk) begin
    if (!rst_n)         sw_hold <= 1'b0;
    else if (sw_strobe) sw_hold <= 1'b1;
    else if (base_rise) sw_hold <= 1'b0;
  end

  assign src_vec = {sw_hold, star_s, line_q, fp_s};

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    trig_line_mux #(.N_DIRECT(N_DIRECT), .SEL_W(SEL_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .src_vec(src_vec),
      .sync_full(base_lvl), .sync_div1(div1_lvl), .sync_div2(div2_lvl),
      .sel(line_src_sel[i*SEL_W +: SEL_W]), .tap(line_tap_sel[i*2 +: 2]),
      .en(line_en[i]), .line_q(line_q[i]), .oe_q(oe_q[i]));
  end

  assign trig_out = line_q;
  assign trig_oe  = oe_q;
endmodule

// File: rtl/trig_route_chk.sv
module trig_route_chk #(
  parameter int N_LINES = 8,
  parameter int N_FP    = 6,
  parameter int EXP_W   = 4,
  parameter int SEL_W   = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_LINES*SEL_W-1:0] line_src_sel,
  input logic [N_LINES-1:0]       line_en,
  input logic                     sw_strobe,
  input logic [N_LINES-1:0]       trig_out,
  input logic [N_LINES-1:0]       trig_oe,
  input logic                     sw_hold,
  input logic                     base_rise,
  input logic                     cfg_restart,
  input logic                     div1_lvl,
  input logic [EXP_W-1:0]         e1c
);
  logic [N_LINES-1:0] fb_hit;
  logic [N_LINES-1:0] fb_pick;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      fb_hit[i]  = 1'b0;
      fb_pick[i] = 1'b0;
      for (int k = 0; k < N_LINES; k++) begin
        if (int'(line_src_sel[i*SEL_W +: SEL_W]) == N_FP + k) begin
          fb_hit[i]  = 1'b1;
          fb_pick[i] = trig_out[k];
        end
      end
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_fb
    a_r3_line_follows_line: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_hit[i] && line_en[i]) |=> (trig_out[i] == $past(fb_pick[i])));
  end

  a_r10_oe_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (trig_oe == $past(line_en)));

  a_r10_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((trig_out & ~trig_oe) == '0));

  a_r9_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sw_strobe |=> sw_hold);

  a_r9_hold_until_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hold && !base_rise && !sw_strobe) |=> sw_hold);

  a_r9_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_hold && base_rise && !sw_strobe) |=> !sw_hold);

  a_r8_restart_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_restart |=> ((e1c == '0) || !div1_lvl));
endmodule

bind trig_route_matrix trig_route_chk #(
  .N_LINES(N_LINES), .N_FP(N_FP), .EXP_W(EXP_W), .SEL_W(SEL_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .line_src_sel(line_src_sel), .line_en(line_en),
  .sw_strobe(sw_strobe), .trig_out(trig_out), .trig_oe(trig_oe),
  .sw_hold(sw_hold), .base_rise(base_rise), .cfg_restart(cfg_restart),
  .div1_lvl(div1_lvl), .e1c(e1c)
);

// File: tb/test_trig_route_matrix.sv
module test_trig_route_matrix;
  localparam int NL = 8;
  localparam int SW = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [5:0]      fp_in = '0;
  logic [16:0]     star_in = '0;
  logic            dds_clk = 1'b0;
  logic            bp_clk10 = 1'b0;
  logic [1:0]      base_sel = '0;
  logic [3:0]      exp1 = '0;
  logic [3:0]      exp2 = '0;
  logic [NL*SW-1:0] line_src_sel = '0;
  logic [NL*2-1:0] line_tap_sel = '0;
  logic [NL-1:0]   line_en = '0;
  logic            sw_strobe = 1'b0;
  logic [NL-1:0]   trig_out;
  logic [NL-1:0]   trig_oe;

  int checks = 0;
  int errors = 0;
  bit dds_run = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  trig_route_matrix i_trig_route_matrix (
    .clk(clk), .rst_n(rst_n), .fp_in(fp_in), .star_in(star_in),
    .dds_clk(dds_clk), .bp_clk10(bp_clk10), .base_sel(base_sel),
    .exp1(exp1), .exp2(exp2), .line_src_sel(line_src_sel),
    .line_tap_sel(line_tap_sel), .line_en(line_en), .sw_strobe(sw_strobe),
    .trig_out(trig_out), .trig_oe(trig_oe));

  // DDS reference: period 4 clocks; backplane reference: period 6 clocks.
  initial begin
    int dc = 0;
    int bc = 0;
    forever begin
      @(negedge clk);
      if (dds_run) begin
        dc++;
        if (dc == 2) begin dc = 0; dds_clk = ~dds_clk; end
      end else begin
        dds_clk = 1'b0;
      end
      bc++;
      if (bc == 3) begin bc = 0; bp_clk10 = ~bp_clk10; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_line(input int i, input int sel, input int tap);
    line_src_sel[i*SW +: SW] = SW'(sel);
    line_tap_sel[i*2 +: 2] = 2'(tap);
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_rise0(output bit ok);
    bit prev = trig_out[0];
    ok = 1'b0;
    for (int k = 0; k < 10000; k++) begin
      @(negedge clk);
      if (trig_out[0] && !prev) begin ok = 1'b1; break; end
      prev = trig_out[0];
    end
  endtask

  task automatic measure0(output int p);
    bit ok;
    bit prev;
    p = -1;
    wait_rise0(ok);
    if (!ok) return;
    prev = 1'b1;
    for (int k = 1; k < 10000; k++) begin
      @(negedge clk);
      if (trig_out[0] && !prev) begin p = k; return; end
      prev = trig_out[0];
    end
  endtask

  // {base_sel, tap, exp1, exp2, period in clocks}
  localparam logic [27:0] VEC [10] = '{
    {2'd0, 2'd0, 4'd0,  4'd0,  16'd4},
    {2'd0, 2'd1, 4'd2,  4'd0,  16'd16},
    {2'd0, 2'd2, 4'd1,  4'd2,  16'd32},
    {2'd1, 2'd1, 4'd3,  4'd0,  16'd48},
    {2'd1, 2'd2, 4'd0,  4'd1,  16'd12},
    {2'd0, 2'd1, 4'd15, 4'd0,  16'd2048},
    {2'd1, 2'd3, 4'd5,  4'd0,  16'd6},
    {2'd0, 2'd2, 4'd0,  4'd0,  16'd4},
    {2'd3, 2'd1, 4'd1,  4'd0,  16'd8},
    {2'd0, 2'd2, 4'd0,  4'd15, 16'd2048}
  };

  initial begin
    int p;
    bit ok;
    cyc(5);
    // R11: reset state
    chk(trig_out == '0, "R11 out in reset", int'(trig_out), 0);
    chk(trig_oe == '0, "R11 oe in reset", int'(trig_oe), 0);
    rst_n = 1'b1;
    cyc(2);

    // Table of divider/tap vectors on line 0 (source code 32)
    line_en = 8'h01;
    for (int v = 0; v < 10; v++) begin
      base_sel = VEC[v][27:26];
      set_line(0, 32, int'(VEC[v][25:24]));
      exp1 = VEC[v][23:20];
      exp2 = VEC[v][19:16];
      cyc(6);
      wait_rise0(ok);
      measure0(p);
      chk(p == int'(VEC[v][15:0]), "R4 R5 R6 R7 sync period", p, int'(VEC[v][15:0]));
    end

    // R2: front-panel input routing latency, R3: line chain
    line_en = 8'hFF;
    set_line(0, 1, 0);
    set_line(1, 6, 0);
    set_line(2, 7, 0);
    set_line(3, 9, 0);
    set_line(4, 30, 0);
    set_line(5, 1, 0);
    set_line(6, 40, 0);
    set_line(7, 31, 0);
    cyc(6);
    fp_in[1] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk(trig_out[0] == 1'b0, "R2 not before third edge", int'(trig_out[0]), 0);
    @(posedge clk); @(negedge clk);
    chk(trig_out[0] == 1'b1, "R2 third edge", int'(trig_out[0]), 1);
    chk(trig_out[1] == 1'b0, "R3 line1 lags", int'(trig_out[1]), 0);
    @(posedge clk); @(negedge clk);
    chk(trig_out[1] == 1'b1, "R3 line1 follows", int'(trig_out[1]), 1);
    chk(trig_out[2] == 1'b0, "R3 line2 lags", int'(trig_out[2]), 0);
    @(posedge clk); @(negedge clk);
    chk(trig_out[2] == 1'b1, "R3 line2 follows", int'(trig_out[2]), 1);
    chk(trig_out[3] == 1'b0, "R3 self select stays low", int'(trig_out[3]), 0);
    chk(trig_out[6] == 1'b0, "R1 code above 32 drives low", int'(trig_out[6]), 0);

    // R1: star line 16
    star_in[16] = 1'b1;
    cyc(4);
    chk(trig_out[4] == 1'b1, "R1 star16 routed", int'(trig_out[4]), 1);

    // R10: enable gating
    line_en[5] = 1'b0;
    cyc(2);
    chk(trig_out[5] == 1'b0 && trig_oe[5] == 1'b0, "R10 disabled line",
        int'({trig_oe[5], trig_out[5]}), 0);
    line_en[5] = 1'b1;
    cyc(2);
    chk(trig_out[5] == 1'b1 && trig_oe[5] == 1'b1, "R10 enabled line",
        int'({trig_oe[5], trig_out[5]}), 3);

    // R9: software trigger with idle front-panel-0 reference
    fp_in[0] = 1'b0;
    base_sel = 2'd2;
    cyc(4);
    chk(trig_out[7] == 1'b0, "R9 idle before strobe", int'(trig_out[7]), 0);
    sw_strobe = 1'b1;
    @(negedge clk);
    sw_strobe = 1'b0;
    cyc(20);
    chk(trig_out[7] == 1'b1, "R9 held while reference idle", int'(trig_out[7]), 1);
    fp_in[0] = 1'b1;
    cyc(6);
    chk(trig_out[7] == 1'b0, "R9 cleared after reference rise", int'(trig_out[7]), 0);

    // R8: restart with stopped DDS reference
    line_en = 8'h01;
    set_line(0, 32, 1);
    base_sel = 2'd0;
    exp1 = 4'd3;
    exp2 = 4'd0;
    cyc(6);
    wait_rise0(ok);
    wait_rise0(ok);
    dds_run = 1'b0;
    cyc(10);
    chk(trig_out[0] == 1'b1, "R8 divided line held high", int'(trig_out[0]), 1);
    base_sel = 2'd3;
    cyc(4);
    chk(trig_out[0] == 1'b0, "R8 restart drops line", int'(trig_out[0]), 0);

    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 150000; k++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule